// File: doc/BRIEF.md
# Integer Register-File Execution Unit

This block keeps thirty-two 32-bit general registers and runs one integer operation per accepted transfer. Each transfer names an operation, a destination register, two source registers, a 16-bit immediate and a 5-bit shift amount. The unit reads both sources in the same cycle. It widens the immediate in the way the operation needs, computes the result and writes it to the destination on the next rising clock edge. Register 0 is wired to zero.

The operation stream uses valid/ready. A transfer happens on a rising edge where `in_valid` and `in_ready` are both high. The unit never applies back-pressure during operation: `in_ready` is high in every cycle outside reset and low while `rst` is high, so an upstream source can issue one operation per cycle. A separate debug read port returns any register combinationally, so the register contents can be inspected.

Top module: `exu_core`

## Requirements
- R1: On a transfer with a recognised operation and a nonzero destination, the result is written on that rising edge. The debug port shows the old value before the edge and the new value after it.
- R2: Register 0 always reads as zero, and an operation that names it as destination changes nothing.
- R3: Operation 0 adds source1 and source2. Operation 2 computes source1 minus source2. Both wrap modulo 2^32 and raise no flag.
- R4: Operation 1 adds the 16-bit immediate to source1 after sign extension to 32 bits, so 0xFFFF acts as minus one.
- R5: Operations 6 (AND), 8 (OR) and 11 (XOR) combine source1 with the zero-extended immediate. The upper 16 bits of an OR or XOR result therefore equal those of source1.
- R6: Operation 3 shifts source1 left and operation 4 shifts it right, both by the shift amount (0 to 31). Vacated positions fill with zeros, including the sign bit on a right shift.
- R7: Operations 5, 7, 9 and 10 give the bitwise AND, OR, NOR and XOR of source1 and source2. NOR with register 0 as source2 gives the bitwise inverse of source1.
- R8: Operation 12 writes the immediate to bits 31:16 and clears bits 15:0. A following OR-immediate completes a full 32-bit constant.
- R9: Operation codes 13 to 15, or a cycle with `in_valid` low, write no register.
- R10: A synchronous reset clears every register to zero, and `in_ready` is low while reset is asserted.
- R11: Outside reset, `in_ready` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation transfer request |
| in_ready | output | 1 | Unit accepts an operation this cycle |
| in_op | input | 4 | Operation code (see requirements) |
| in_rd | input | 5 | Destination register index |
| in_rs | input | 5 | Source1 register index |
| in_rt | input | 5 | Source2 register index |
| in_imm | input | 16 | Immediate field |
| in_shamt | input | 5 | Shift amount |
| dbg_idx | input | 5 | Debug read index |
| dbg_data | output | 32 | Debug read data |

## Verification
The bench targets the places where the immediate is widened the wrong way. With sign extension applied everywhere, OR-immediate 0xFFFF would set the upper half; with zero extension applied to add-immediate, an add of 0xFFFF would add 65535 instead of subtracting one. It reverses the subtract operands, shifts right the value 0xB8000009 to catch an arithmetic fill, shifts by 0 and 31, wraps an add past 2^32 and writes to register 0. It also reads a register in the cycle it is written, to catch a design that forwards the new value or writes a cycle late. Undefined operation codes and idle cycles are issued against live registers, which would expose a unit that writes on them.

// File: rtl/exu_pkg.sv
package exu_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RIDX = $clog2(NREG);
  localparam int IMMW = 16;
  localparam int SHW  = $clog2(XLEN);
  localparam int OPW  = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDI = 4'd1,
    OP_SUB  = 4'd2,
    OP_SLL  = 4'd3,
    OP_SRL  = 4'd4,
    OP_AND  = 4'd5,
    OP_ANDI = 4'd6,
    OP_OR   = 4'd7,
    OP_ORI  = 4'd8,
    OP_NOR  = 4'd9,
    OP_XOR  = 4'd10,
    OP_XORI = 4'd11,
    OP_LUI  = 4'd12
  } op_e;
endpackage

// File: rtl/exu_regfile.sv
module exu_regfile #(
  parameter int W    = 32,
  parameter int N    = 32,
  parameter int NRD  = 3,
  localparam int AW  = $clog2(N)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_idx,
  input  logic [W-1:0]           wr_data,
  input  logic [NRD-1:0][AW-1:0] rd_idx,
  output logic [NRD-1:0][W-1:0]  rd_data
);
  logic [W-1:0] mem [N];

  // Entry 0 is cleared by reset and never written afterwards.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem <= '{default: '0};
    end else if (wr_en && (wr_idx != '0)) begin
      mem[wr_idx] <= wr_data;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = mem[rd_idx[g]];
  end

  // R1: an accepted write to a nonzero entry is held the following cycle
  a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx != '0) |=> (mem[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/exu_imm_ext.sv
module exu_imm_ext
  import exu_pkg::*;
(
  input  op_e              op,
  input  logic [IMMW-1:0]  imm,
  output logic [XLEN-1:0]  imm_w
);
  localparam int PADW = XLEN - IMMW;

  always_comb begin
    case (op)
      OP_ADDI:                  imm_w = {{PADW{imm[IMMW-1]}}, imm};
      OP_ANDI, OP_ORI, OP_XORI: imm_w = {{PADW{1'b0}}, imm};
      OP_LUI:                   imm_w = {imm, {PADW{1'b0}}};
      default:                  imm_w = '0;
    endcase
  end
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
(
  input  op_e             op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [XLEN-1:0] imm_w,
  input  logic [SHW-1:0]  shamt,
  output logic [XLEN-1:0] res,
  output logic            known
);
  always_comb begin
    known = 1'b1;
    case (op)
      OP_ADD:  res = a + b;
      OP_ADDI: res = a + imm_w;
      OP_SUB:  res = a - b;
      OP_SLL:  res = a << shamt;
      OP_SRL:  res = a >> shamt;
      OP_AND:  res = a & b;
      OP_ANDI: res = a & imm_w;
      OP_OR:   res = a | b;
      OP_ORI:  res = a | imm_w;
      OP_NOR:  res = ~(a | b);
      OP_XOR:  res = a ^ b;
      OP_XORI: res = a ^ imm_w;
      OP_LUI:  res = imm_w;
      default: begin
        res   = '0;
        known = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OPW-1:0]  in_op,
  input  logic [RIDX-1:0] in_rd,
  input  logic [RIDX-1:0] in_rs,
  input  logic [RIDX-1:0] in_rt,
  input  logic [IMMW-1:0] in_imm,
  input  logic [SHW-1:0]  in_shamt,
  input  logic [RIDX-1:0] dbg_idx,
  output logic [XLEN-1:0] dbg_data
);
  localparam int NRD = 3;

  op_e                        op;
  logic [XLEN-1:0]            src_a;
  logic [XLEN-1:0]            src_b;
  logic [XLEN-1:0]            imm_w;
  logic [XLEN-1:0]            res;
  logic                       known;
  logic                       wr_en;
  logic [NRD-1:0][RIDX-1:0]   rd_idx;
  logic [NRD-1:0][XLEN-1:0]   rd_data;

  assign op       = op_e'(in_op);
  assign in_ready = !rst;
  assign wr_en    = in_valid && in_ready && known;

  assign rd_idx   = {dbg_idx, in_rt, in_rs};
  assign src_a    = rd_data[0];
  assign src_b    = rd_data[1];
  assign dbg_data = rd_data[2];

  exu_imm_ext u_ext (
    .op    (op),
    .imm   (in_imm),
    .imm_w (imm_w)
  );

  exu_alu u_alu (
    .op    (op),
    .a     (src_a),
    .b     (src_b),
    .imm_w (imm_w),
    .shamt (in_shamt),
    .res   (res),
    .known (known)
  );

  exu_regfile #(.W(XLEN), .N(NREG), .NRD(NRD)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (in_rd),
    .wr_data (res),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  // R5: OR-immediate keeps the upper half of source1
  a_r5_ori_upper: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op == OP_ORI) |-> (res[XLEN-1:IMMW] == src_a[XLEN-1:IMMW]));

  // R6: a nonzero logical right shift clears the top bit
  a_r6_srl_fill: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op == OP_SRL && in_shamt != '0) |-> !res[XLEN-1]);

  // R8: upper-immediate load leaves the low half clear
  a_r8_lui_low: assert property (@(posedge clk) disable iff (rst)
    (wr_en && op == OP_LUI) |-> (res[IMMW-1:0] == '0));

  // R9: without a write the watched register holds its value
  a_r9_no_write_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=> ($stable(dbg_data) || !$stable(dbg_idx)));

  // R10: the first cycle after reset sees cleared registers
  a_r10_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dbg_data == '0));
endmodule

// File: tb/tb_exu_core.sv
module tb_exu_core;
  import exu_pkg::*;

  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 24;

  typedef struct packed {
    op_e         op;
    logic [4:0]  rd;
    logic [4:0]  rs;
    logic [4:0]  rt;
    logic [15:0] imm;
    logic [4:0]  sh;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{OP_LUI,  5'd1,  5'd0,  5'd0, 16'hAAAA, 5'd0,  32'hAAAA0000}, // R8
    '{OP_ORI,  5'd1,  5'd1,  5'd0, 16'hF0F0, 5'd0,  32'hAAAAF0F0}, // R8 R5
    '{OP_ORI,  5'd2,  5'd0,  5'd0, 16'h0009, 5'd0,  32'h00000009}, // R5
    '{OP_LUI,  5'd3,  5'd0,  5'd0, 16'hB800, 5'd0,  32'hB8000000}, // R8
    '{OP_ORI,  5'd3,  5'd3,  5'd0, 16'h0009, 5'd0,  32'hB8000009}, // R5
    '{OP_SLL,  5'd4,  5'd3,  5'd0, 16'h0000, 5'd4,  32'h80000090}, // R6
    '{OP_SRL,  5'd5,  5'd3,  5'd0, 16'h0000, 5'd4,  32'h0B800000}, // R6 zero fill
    '{OP_SRL,  5'd6,  5'd3,  5'd0, 16'h0000, 5'd31, 32'h00000001}, // R6 max
    '{OP_SLL,  5'd7,  5'd2,  5'd0, 16'h0000, 5'd0,  32'h00000009}, // R6 zero
    '{OP_ADDI, 5'd8,  5'd2,  5'd0, 16'hFFFF, 5'd0,  32'h00000008}, // R4
    '{OP_ADDI, 5'd9,  5'd0,  5'd0, 16'h8000, 5'd0,  32'hFFFF8000}, // R4
    '{OP_ADD,  5'd10, 5'd1,  5'd2, 16'h0000, 5'd0,  32'hAAAAF0F9}, // R3
    '{OP_SUB,  5'd11, 5'd2,  5'd1, 16'h0000, 5'd0,  32'h55550F19}, // R3
    '{OP_SUB,  5'd12, 5'd1,  5'd2, 16'h0000, 5'd0,  32'hAAAAF0E7}, // R3 order
    '{OP_ADD,  5'd13, 5'd9,  5'd9, 16'h0000, 5'd0,  32'hFFFF0000}, // R3 wrap
    '{OP_NOR,  5'd14, 5'd1,  5'd0, 16'h0000, 5'd0,  32'h55550F0F}, // R7 not
    '{OP_AND,  5'd15, 5'd1,  5'd3, 16'h0000, 5'd0,  32'hA8000000}, // R7
    '{OP_OR,   5'd16, 5'd1,  5'd3, 16'h0000, 5'd0,  32'hBAAAF0F9}, // R7
    '{OP_XOR,  5'd17, 5'd1,  5'd3, 16'h0000, 5'd0,  32'h12AAF0F9}, // R7
    '{OP_ANDI, 5'd18, 5'd1,  5'd0, 16'hFFFF, 5'd0,  32'h0000F0F0}, // R5
    '{OP_XORI, 5'd19, 5'd1,  5'd0, 16'hFFFF, 5'd0,  32'hAAAA0F0F}, // R5
    '{OP_ORI,  5'd20, 5'd9,  5'd0, 16'h0001, 5'd0,  32'hFFFF8001}, // R5 upper kept
    '{OP_ADDI, 5'd21, 5'd1,  5'd0, 16'h7FFF, 5'd0,  32'hAAAB70EF}, // R4
    '{OP_ADD,  5'd0,  5'd1,  5'd1, 16'h0000, 5'd0,  32'h00000000}  // R2
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic [4:0]  in_rd = '0;
  logic [4:0]  in_rs = '0;
  logic [4:0]  in_rt = '0;
  logic [15:0] in_imm = '0;
  logic [4:0]  in_shamt = '0;
  logic [4:0]  dbg_idx = '0;
  logic [31:0] dbg_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  exu_core dut (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_op    (in_op),
    .in_rd    (in_rd),
    .in_rs    (in_rs),
    .in_rt    (in_rt),
    .in_imm   (in_imm),
    .in_shamt (in_shamt),
    .dbg_idx  (dbg_idx),
    .dbg_data (dbg_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [4:0] idx, input string req, input logic [31:0] exp);
    dbg_idx = idx;
    #1;
    check(req, dbg_data, exp);
  endtask

  // Drives one operation at a falling edge; it is taken at the next rising edge.
  task automatic issue(input logic v, input logic [3:0] op, input logic [4:0] rd,
                       input logic [4:0] rs, input logic [4:0] rt,
                       input logic [15:0] imm, input logic [4:0] sh);
    @(negedge clk);
    in_valid = v; in_op = op; in_rd = rd; in_rs = rs; in_rt = rt;
    in_imm = imm; in_shamt = sh;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R10 ready low in reset", {31'd0, in_ready}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check("R11 ready high", {31'd0, in_ready}, 32'd1);
    peek(5'd7,  "R10 cleared r7",  32'd0);
    peek(5'd31, "R10 cleared r31", 32'd0);

    for (int i = 0; i < NV; i++) begin
      issue(1'b1, VEC[i].op, VEC[i].rd, VEC[i].rs, VEC[i].rt, VEC[i].imm, VEC[i].sh);
      peek(VEC[i].rd, $sformatf("vector %0d", i), VEC[i].exp);
    end

    // R2: register 0 as destination of LUI stays zero
    issue(1'b1, OP_LUI, 5'd0, 5'd0, 5'd0, 16'h1234, 5'd0);
    peek(5'd0, "R2 r0 after lui", 32'd0);

    // R9: undefined codes 13..15 leave r1 untouched
    for (int c = 13; c < 16; c++) begin
      issue(1'b1, 4'(c), 5'd1, 5'd2, 5'd2, 16'hFFFF, 5'd1);
      peek(5'd1, "R9 undefined op", 32'hAAAAF0F0);
    end
    // R9: valid low does not write
    issue(1'b0, OP_ADD, 5'd2, 5'd1, 5'd1, 16'h0000, 5'd0);
    peek(5'd2, "R9 valid low", 32'h00000009);

    // R1: same-cycle read shows old value, new after the edge
    @(negedge clk);
    in_valid = 1'b1; in_op = OP_ADDI; in_rd = 5'd2; in_rs = 5'd2; in_imm = 16'h0001;
    dbg_idx = 5'd2;
    #1;
    check("R1 old value before edge", dbg_data, 32'h00000009);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check("R1 new value after edge", dbg_data, 32'h0000000A);

    // R10: mid-run synchronous reset
    @(negedge clk);
    rst = 1'b1;
    #1;
    check("R10 ready low", {31'd0, in_ready}, 32'd0);
    check("R10 value held until edge", dbg_data, 32'h0000000A);
    @(negedge clk);
    rst = 1'b0;
    peek(5'd1, "R10 r1 cleared", 32'd0);
    peek(5'd2, "R10 r2 cleared", 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule